// File: doc/BRIEF.md
# Dual-Path Registered Bus Transceiver

This block moves 18-bit words between two ports, A and B, over two separate paths: one from A to B and one from B to A. Each path holds one storage register and works in one of three ways. With its latch enable high it is transparent, and the output follows the input. With the latch enable low and the path clock steady, the output keeps its stored value. With the latch enable low, a falling edge on the path clock stores the word present at the input.

Each direction has its own output enable. The A-to-B enable is active high and the B-to-A enable is active low. Instead of tri-state pins, each port has a separate input vector, output vector and output-valid flag, so the block can be synthesized. A disabled output appears as its output-valid flag held low.

Everything runs on one system clock. Each path clock pin passes through a two-stage synchronizer, and a falling edge is found by comparing the current synchronized sample with the previous one. A stored word therefore appears at most four system cycles after the path clock pin falls. This assumes the input data stays steady over that window.

Top module: `regxcvr`

## Requirements
- R1: Each path is 18 bits wide and keeps its own storage register, and every bit passes through unchanged (checked with all-ones, all-zeros and alternating patterns).
- R2: While a path's latch enable is 1, its output equals its input in the same cycle.
- R3: While a path's latch enable is 0 and its path clock pin is steady, the path output does not change, whatever happens on its input.
- R4: While the latch enable is 0, a 1-to-0 transition of the path clock pin stores the input word, and the output shows it no later than 4 system cycles after the pin changes. A 0-to-1 transition stores nothing.
- R5: `b_out_en` is 1 exactly when `ab_oe` is 1, and `a_out_en` is 1 exactly when `ba_oe_n` is 0, outside reset.
- R6: Enable, clock and data activity on one path never changes the output of the other path.
- R7: When the latch enable goes from 1 to 0 and no path clock fall occurs, the output keeps the input word from the last transparent cycle, even if the input changes in the same cycle.
- R8: When the latch enable falls in the same cycle as the path clock pin falls, the word on the input when the edge is detected is stored.
- R9: A synchronous active-high `rst` clears both storage registers to zero and holds both output-valid flags at 0.
- R10: Storage works the same way while an output is disabled, and the stored word appears once the output is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 18 | Word arriving on port A |
| b_in | input | 18 | Word arriving on port B |
| ab_le | input | 1 | A-to-B latch enable, 1 = transparent |
| ab_clk | input | 1 | A-to-B path clock, stores on its falling edge |
| ab_oe | input | 1 | A-to-B output enable, active high |
| ba_le | input | 1 | B-to-A latch enable, 1 = transparent |
| ba_clk | input | 1 | B-to-A path clock, stores on its falling edge |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| b_out | output | 18 | Word driven toward port B |
| b_out_en | output | 1 | 1 when port B is driven |
| a_out | output | 18 | Word driven toward port A |
| a_out_en | output | 1 | 1 when port A is driven |

## Verification
The assertions check on every cycle:
- the enable polarities and their forcing to 0 during reset;
- that the output after a latch-enable fall equals the last transparent input;
- that an output stays still while its latch enable is low and its path clock pin has been quiet for four cycles.

Only the bench scenarios can show the rest:
- that a falling path clock edge stores the right word within the synchronizer window, and a rising edge stores nothing;
- the same-cycle latch-enable and clock fall;
- that the two paths are independent;
- that words stored while an output is disabled appear once it is enabled.

// File: rtl/regxcvr.sv
module regxcvr #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         ab_le,
  input  logic         ab_clk,
  input  logic         ab_oe,
  input  logic         ba_le,
  input  logic         ba_clk,
  input  logic         ba_oe_n,
  output logic [W-1:0] b_out,
  output logic         b_out_en,
  output logic [W-1:0] a_out,
  output logic         a_out_en
);
  logic [1:0][W-1:0] din, q;
  logic [1:0]        le, pclk;

  assign din  = {b_in, a_in};
  assign le   = {ba_le, ab_le};
  assign pclk = {ba_clk, ab_clk};

  for (genvar g = 0; g < 2; g++) begin : g_path
    logic [2:0]   sy;
    logic [W-1:0] st;
    logic         fall;
    assign fall = sy[2] & ~sy[1];
    always_ff @(posedge clk) begin
      if (rst) begin
        sy <= '0;
        st <= '0;
      end else begin
        sy <= {sy[1:0], pclk[g]};
        if (le[g] || fall) st <= din[g];
      end
    end
    assign q[g] = st;
  end

  assign b_out    = ab_le ? a_in : q[0];
  assign a_out    = ba_le ? b_in : q[1];
  assign b_out_en = ab_oe & ~rst;
  assign a_out_en = ~ba_oe_n & ~rst;
endmodule

module regxcvr_chk #(
  parameter int W = 18
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic         ab_le,
  input logic         ab_clk,
  input logic         ab_oe,
  input logic         ba_le,
  input logic         ba_clk,
  input logic         ba_oe_n,
  input logic [W-1:0] b_out,
  input logic         b_out_en,
  input logic [W-1:0] a_out,
  input logic         a_out_en
);
  logic [2:0] quiet_ab, quiet_ba;
  logic       prev_ab, prev_ba;

  always_ff @(posedge clk) begin
    if (rst) begin
      quiet_ab <= '0;
      quiet_ba <= '0;
    end else begin
      quiet_ab <= (ab_clk != prev_ab) ? 3'd0 : (quiet_ab == 3'd7 ? 3'd7 : quiet_ab + 3'd1);
      quiet_ba <= (ba_clk != prev_ba) ? 3'd0 : (quiet_ba == 3'd7 ? 3'd7 : quiet_ba + 3'd1);
    end
    prev_ab <= ab_clk;
    prev_ba <= ba_clk;
  end

  AST_RESET_OE: assert property (@(posedge clk) rst |-> !b_out_en && !a_out_en); // R9
  AST_AB_OE_POL: assert property (@(posedge clk) disable iff (rst) !ab_oe |-> !b_out_en); // R5
  AST_BA_OE_POL: assert property (@(posedge clk) disable iff (rst) ba_oe_n |-> !a_out_en); // R5
  AST_AB_LE_FALL: assert property (@(posedge clk) disable iff (rst)
    $fell(ab_le) && quiet_ab >= 3'd4 |-> b_out == $past(a_in)); // R7
  AST_BA_LE_FALL: assert property (@(posedge clk) disable iff (rst)
    $fell(ba_le) && quiet_ba >= 3'd4 |-> a_out == $past(b_in)); // R7
  AST_AB_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ab_le && $past(!ab_le) && quiet_ab >= 3'd4 |-> $stable(b_out)); // R3
  AST_BA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ba_le && $past(!ba_le) && quiet_ba >= 3'd4 |-> $stable(a_out)); // R3
endmodule

bind regxcvr regxcvr_chk #(.W(W)) u_chk (.*);

// File: tb/regxcvr_bench.sv
`timescale 1ns/1ps
module regxcvr_bench;
  localparam int W = 18;
  logic clk = 0, rst = 1;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic ab_le = 0, ab_clk = 0, ab_oe = 0, ba_le = 0, ba_clk = 0, ba_oe_n = 1;
  logic [W-1:0] b_out, a_out;
  logic b_out_en, a_out_en;
  int errors = 0, checks = 0;
  logic [W-1:0] exp_q [2];
  bit done = 0;

  always #4 clk = ~clk;

  regxcvr #(.W(W)) u_regxcvr (.*);

  function automatic logic exp_b_en(logic oe);   return oe;  endfunction
  function automatic logic exp_a_en(logic oe_n); return ~oe_n; endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(int n); repeat (n) @(negedge clk); endtask

  task automatic set_le(int d, logic v);  if (d == 0) ab_le = v;  else ba_le = v;  endtask
  task automatic set_pc(int d, logic v);  if (d == 0) ab_clk = v; else ba_clk = v; endtask
  task automatic set_din(int d, logic [W-1:0] v); if (d == 0) a_in = v; else b_in = v; endtask
  function automatic logic [W-1:0] out_of(int d); return d == 0 ? b_out : a_out; endfunction
  function automatic logic pc_of(int d); return d == 0 ? ab_clk : ba_clk; endfunction

  task automatic chk_en();
    #1;
    chk("R5 b_out_en", W'(b_out_en), W'(exp_b_en(ab_oe)));
    chk("R5 a_out_en", W'(a_out_en), W'(exp_a_en(ba_oe_n)));
  endtask

  task automatic chk_other(int d);
    chk("R6 other path unchanged", out_of(1 - d), exp_q[1 - d]);
  endtask

  task automatic op_transparent(int d, logic [W-1:0] x);
    set_le(d, 1); set_din(d, x); #1;
    chk("R2 transparent", out_of(d), x);
    step(1);
    set_le(d, 0); set_din(d, ~x); #1;
    chk("R7 keeps last transparent word", out_of(d), x);
    exp_q[d] = x;
    step(5);
    chk("R7 still held", out_of(d), x);
  endtask

  task automatic op_hold(int d, logic [W-1:0] x);
    set_din(d, x); step(6);
    chk("R3 hold with steady clock", out_of(d), exp_q[d]);
  endtask

  task automatic op_capture(int d, logic [W-1:0] y, logic [W-1:0] x);
    if (pc_of(d) == 1'b0) begin
      set_din(d, y); set_pc(d, 1); step(5);
      chk("R4 rising edge stores nothing", out_of(d), exp_q[d]);
    end
    set_din(d, x); set_pc(d, 0); step(5);
    chk("R4 falling edge stores", out_of(d), x);
    exp_q[d] = x;
  endtask

  task automatic op_simul(int d, logic [W-1:0] x1, logic [W-1:0] x2);
    set_le(d, 1); set_pc(d, 1); set_din(d, x1); step(5);
    set_le(d, 0); set_pc(d, 0); set_din(d, x2); #1;
    chk("R8 output before edge detected", out_of(d), x1);
    step(5);
    chk("R8 same-cycle edge stores", out_of(d), x2);
    exp_q[d] = x2;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    exp_q[0] = '0; exp_q[1] = '0;
    step(3);
    #1;
    chk("R9 b_out_en in reset", W'(b_out_en), '0);
    chk("R9 a_out_en in reset", W'(a_out_en), '0);
    rst = 0; ab_oe = 1; ba_oe_n = 0;
    step(1);
    #1;
    chk("R9 b storage cleared", b_out, '0);
    chk("R9 a storage cleared", a_out, '0);
    chk_en();

    op_transparent(0, 18'h3FFFF); chk("R1 all ones", b_out, 18'h3FFFF);
    op_transparent(1, 18'h2AAAA); chk("R1 alternating", a_out, 18'h2AAAA);
    op_capture(0, 18'h15555, 18'h00000); chk("R1 all zeros", b_out, 18'h00000);
    op_hold(1, 18'h12345);
    op_simul(0, 18'h0F0F0, 18'h30303); chk_other(0);
    op_simul(1, 18'h11111, 18'h22222); chk_other(1);

    ab_oe = 0; chk_en();
    op_capture(0, 18'h0ABCD, 18'h1DCBA);
    ab_oe = 1; chk_en();
    chk("R10 stored while disabled", b_out, 18'h1DCBA);
    ba_oe_n = 1; chk_en();
    op_transparent(1, 18'h05A5A);
    ba_oe_n = 0; chk_en();
    chk("R10 stored while disabled", a_out, 18'h05A5A);

    for (int i = 0; i < 300; i++) begin
      int d = $urandom_range(0, 1);
      int op = $urandom_range(0, 3);
      logic [W-1:0] x = W'($urandom), y = W'($urandom);
      ab_oe = 1'($urandom); ba_oe_n = 1'($urandom);
      chk_en();
      case (op)
        0: op_transparent(d, x);
        1: op_hold(d, x);
        2: op_capture(d, y, x);
        default: op_simul(d, y, x);
      endcase
      chk_other(d);
    end

    rst = 1; step(1); #1;
    chk("R9 enables off in reset", W'({b_out_en, a_out_en}), '0);
    rst = 0; step(1); #1;
    chk("R9 storage cleared again", b_out, '0);
    chk("R9 storage cleared again", a_out, '0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule